// File: doc/BRIEF.md
# Four-Tap Multiply-Accumulate Filter Core

This block is a clocked sum-of-products engine for small image-filter kernels. Four signed sample inputs and four signed weight inputs each sit in their own capture register. A per-tap keep flag and one shared keep-select decide on every rising edge which of those registers take new values. The four captured products are added together. The sum either starts a new accumulation or is added to the running total held in a 32-bit accumulator.

A mode input picks how the 16-bit result is cut from the accumulator. Integer mode takes the low half with no alignment. Fractional mode left-aligns the product sum and takes the high half. A fractional cycle that starts a new accumulation also adds a half-LSB rounding bias. Later accumulating cycles inherit that bias and add none of their own, so one rounding covers a whole summation. The result leaves through a register. An active-low output enable gates it to zero and raises a separate drive flag, which stands in for real three-state pins.

Top module: `mac4_filter`

## Requirements
- R1: When tap_keep_i[n] is 0, both the sample register and the weight register of tap n load on the rising edge (bit n of each flat bus, samples at data_i[10n+9:10n], weights at coef_i[11n+10:11n], two's complement).
- R2: When tap_keep_i[n] is 1 and keep_sel_i is 0, the sample register of tap n loads and its weight register holds.
- R3: When tap_keep_i[n] is 1 and keep_sel_i is 1, the weight register of tap n loads and its sample register holds.
- R4: With int_mode_i = 1 the product sum enters the accumulator unshifted, res_o shows accumulator bits 15..0, and no rounding is added.
- R5: With int_mode_i = 0 the sign-extended product sum is shifted left by 11 before it enters the accumulator, and res_o shows accumulator bits 31..16.
- R6: With accum_i = 0 the previous accumulator contents are discarded and only the current product sum (plus any bias from R8) is kept.
- R7: With accum_i = 1 the current aligned product sum is added to the accumulator, with no rounding bias.
- R8: A rounding bias of 2^15 is added into the accumulator only on a cycle with int_mode_i = 0 and accum_i = 0.
- R9: accum_i and int_mode_i are captured on the same edge as the samples and weights they apply to. The result for inputs captured on edge k appears on res_o after edge k+2.
- R10: While oe_n_i is 1, res_o reads all zeros and res_drv_o is 0, without delay. When oe_n_i returns to 0, the unchanged register value is shown and res_drv_o is 1.
- R11: Driving rst_n low clears every register at once, so res_o reads zero. Release takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_keep_i | input | 4 | Per-tap keep flags; 0 loads both registers of that tap |
| keep_sel_i | input | 1 | For kept taps: 0 loads samples, 1 loads weights |
| data_i | input | 40 | Four packed signed 10-bit samples, tap 0 lowest |
| coef_i | input | 44 | Four packed signed 11-bit weights, tap 0 lowest |
| accum_i | input | 1 | 1 adds to the running total, 0 starts a new one |
| int_mode_i | input | 1 | 1 integer alignment, 0 fractional alignment |
| oe_n_i | input | 1 | Active-low output enable |
| res_o | output | 16 | Registered result, zero while disabled |
| res_drv_o | output | 1 | High while the result is driven |

## Verification
The bench builds the block with its default parameters: four taps, 10-bit samples, 11-bit weights and a 32-bit accumulator. With these values the fractional shift is 11 bits and the rounding bias sits at bit 15. Small weights such as 15 and 16 then land right at the rounding threshold, which separates biased results from unbiased ones and single bias from double bias. Full-scale samples and weights make the integer sum spill past 16 bits, which exercises the low-half cut.

// File: rtl/mac4_pkg.sv
package mac4_pkg;

  typedef struct packed {
    logic accum;
    logic int_mode;
  } mac_ctl_t;

endpackage

// File: rtl/mac4_rst_sync.sv
module mac4_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/mac4_tap_reg.sv
module mac4_tap_reg #(
  parameter int DW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          keep_i,
  input  logic          sel_w_i,
  input  logic [DW-1:0] d_i,
  input  logic [CW-1:0] c_i,
  output logic [DW-1:0] d_o,
  output logic [CW-1:0] c_o
);

  logic          d_en, c_en;
  logic [DW-1:0] d_q, d_nxt;
  logic [CW-1:0] c_q, c_nxt;

  always_comb begin
    d_en  = !keep_i || !sel_w_i;
    c_en  = !keep_i ||  sel_w_i;
    d_nxt = d_en ? d_i : d_q;
    c_nxt = c_en ? c_i : c_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q <= '0;
      c_q <= '0;
    end else begin
      d_q <= d_nxt;
      c_q <= c_nxt;
    end
  end

  assign d_o = d_q;
  assign c_o = c_q;

  p_load_both_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !keep_i |=> (d_q == $past(d_i)) && (c_q == $past(c_i)));

  p_weight_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_i && !sel_w_i) |=> $stable(c_q) && (d_q == $past(d_i)));

  p_sample_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_i && sel_w_i) |=> $stable(d_q) && (c_q == $past(c_i)));

endmodule

// File: rtl/mac4_acc_stage.sv
module mac4_acc_stage
  import mac4_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int DW    = 10,
  parameter int CW    = 11,
  parameter int AW    = 32,
  parameter int OW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTAPS*DW-1:0] d_flat_i,
  input  logic [NTAPS*CW-1:0] c_flat_i,
  input  mac_ctl_t            ctl_i,
  output logic [AW-1:0]       acc_o,
  output logic                int_o
);

  localparam int PW       = DW + CW;
  localparam int SW       = PW + $clog2(NTAPS);
  localparam int SH       = AW - PW;
  localparam int HALF_BIT = AW - OW - 1;
  localparam logic [AW-1:0] HALF = {{(AW-1){1'b0}}, 1'b1} << HALF_BIT;

  mac_ctl_t              ctl_q;
  logic                  int_q;
  logic signed [SW-1:0]  prod [NTAPS];
  logic signed [SW-1:0]  psum;
  logic signed [AW-1:0]  wide;
  logic        [AW-1:0]  aligned, acc_q, acc_nxt, bias;

  for (genvar t = 0; t < NTAPS; t++) begin : g_prod
    logic signed [DW-1:0] dv;
    logic signed [CW-1:0] cv;
    assign dv      = d_flat_i[t*DW +: DW];
    assign cv      = c_flat_i[t*CW +: CW];
    assign prod[t] = SW'(dv) * SW'(cv);
  end

  always_comb begin
    psum = '0;
    for (int t = 0; t < NTAPS; t++) psum = psum + prod[t];
    wide    = AW'(psum);
    aligned = ctl_q.int_mode ? wide : (wide <<< SH);
    bias    = (!ctl_q.accum && !ctl_q.int_mode) ? HALF : '0;
    acc_nxt = (ctl_q.accum ? acc_q : '0) + aligned + bias;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      int_q <= 1'b0;
      acc_q <= '0;
    end else begin
      ctl_q <= ctl_i;
      int_q <= ctl_q.int_mode;
      acc_q <= acc_nxt;
    end
  end

  assign acc_o = acc_q;
  assign int_o = int_q;

  p_accum_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q.accum |=> (acc_q - $past(acc_q)) == $past(aligned));

  p_round_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.accum && !ctl_q.int_mode) |=> (acc_q - $past(aligned)) == HALF);

  p_int_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.accum && ctl_q.int_mode) |=> acc_q == $past(aligned));

endmodule

// File: rtl/mac4_out_stage.sv
module mac4_out_stage #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] acc_i,
  input  logic          int_i,
  input  logic          oe_n_i,
  output logic [OW-1:0] res_o,
  output logic          drv_o
);

  logic [OW-1:0] res_q, res_nxt;

  always_comb begin
    res_nxt = int_i ? acc_i[OW-1:0] : acc_i[AW-1 -: OW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_nxt;
  end

  assign res_o = oe_n_i ? '0 : res_q;
  assign drv_o = !oe_n_i;

  p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drv_o |-> (res_o == res_q));

endmodule

// File: rtl/mac4_filter.sv
module mac4_filter
  import mac4_pkg::*;
#(
  parameter int NTAPS = 4,
  parameter int DW    = 10,
  parameter int CW    = 11,
  parameter int AW    = 32,
  parameter int OW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTAPS-1:0]    tap_keep_i,
  input  logic                keep_sel_i,
  input  logic [NTAPS*DW-1:0] data_i,
  input  logic [NTAPS*CW-1:0] coef_i,
  input  logic                accum_i,
  input  logic                int_mode_i,
  input  logic                oe_n_i,
  output logic [OW-1:0]       res_o,
  output logic                res_drv_o
);

  logic                rst_sn;
  logic [NTAPS*DW-1:0] d_flat;
  logic [NTAPS*CW-1:0] c_flat;
  logic [AW-1:0]       acc;
  logic                acc_int;
  mac_ctl_t            ctl;

  assign ctl.accum    = accum_i;
  assign ctl.int_mode = int_mode_i;

  mac4_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_sn(rst_sn)
  );

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    mac4_tap_reg #(.DW(DW), .CW(CW)) u_tap (
      .clk    (clk),
      .rst_n  (rst_sn),
      .keep_i (tap_keep_i[t]),
      .sel_w_i(keep_sel_i),
      .d_i    (data_i[t*DW +: DW]),
      .c_i    (coef_i[t*CW +: CW]),
      .d_o    (d_flat[t*DW +: DW]),
      .c_o    (c_flat[t*CW +: CW])
    );
  end

  mac4_acc_stage #(.NTAPS(NTAPS), .DW(DW), .CW(CW), .AW(AW), .OW(OW)) u_acc (
    .clk     (clk),
    .rst_n   (rst_sn),
    .d_flat_i(d_flat),
    .c_flat_i(c_flat),
    .ctl_i   (ctl),
    .acc_o   (acc),
    .int_o   (acc_int)
  );

  mac4_out_stage #(.AW(AW), .OW(OW)) u_out (
    .clk   (clk),
    .rst_n (rst_sn),
    .acc_i (acc),
    .int_i (acc_int),
    .oe_n_i(oe_n_i),
    .res_o (res_o),
    .drv_o (res_drv_o)
  );

  p_reset_clear_r11: assert property (@(posedge clk)
    !rst_n |-> (res_o == '0));

endmodule

// File: tb/tb_mac4_filter.sv
`timescale 1ns/1ps
module tb_mac4_filter;

  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  tap_keep_i;
  logic        keep_sel_i;
  logic [39:0] data_i;
  logic [43:0] coef_i;
  logic        accum_i, int_mode_i, oe_n_i;
  logic [15:0] res_o;
  logic        res_drv_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mac4_filter dut (
    .clk(clk), .rst_n(rst_n), .tap_keep_i(tap_keep_i), .keep_sel_i(keep_sel_i),
    .data_i(data_i), .coef_i(coef_i), .accum_i(accum_i), .int_mode_i(int_mode_i),
    .oe_n_i(oe_n_i), .res_o(res_o), .res_drv_o(res_drv_o)
  );

  localparam int KEEP_T [NV] = '{0, 0, 15, 15, 5, 0, 0, 0, 0, 0, 0, 0};
  localparam int SEL_T  [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};
  localparam int ACC_T  [NV] = '{0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};
  localparam int INT_T  [NV] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam int D_T [NV][4] = '{
    '{1, 2, 3, 4}, '{-1, 0, 0, 0}, '{2, 2, 2, 2}, '{9, 9, 9, 9},
    '{3, 3, 3, 3}, '{256, 0, 0, 0}, '{1, 0, 0, 0}, '{1, 0, 0, 0},
    '{1, 0, 0, 0}, '{-1, 0, 0, 0}, '{-3, 0, 0, 0}, '{511, 511, 511, 511}};
  localparam int C_T [NV][4] = '{
    '{5, 6, 7, 8}, '{10, 0, 0, 0}, '{100, 100, 100, 100}, '{1, 2, 3, 5},
    '{7, 7, 7, 7}, '{512, 0, 0, 0}, '{16, 0, 0, 0}, '{15, 0, 0, 0},
    '{1, 0, 0, 0}, '{16, 0, 0, 0}, '{5, 0, 0, 0}, '{1023, 1023, 1023, 1023}};
  localparam logic [15:0] EXP_T [NV] = '{
    16'd70, 16'd60, 16'd20, 16'd22, 16'd54, 16'h1000,
    16'd1, 16'd1, 16'd1, 16'h0000, 16'hFFF1, 16'hE804};

  string tags [NV] = '{
    "R1/R4", "R7/R4", "R2", "R3", "R1/R2", "R5/R8",
    "R8/R6", "R7", "R7/R8", "R8/R5", "R4/R6", "R4"};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input int j);
    tap_keep_i = 4'(KEEP_T[j]);
    keep_sel_i = SEL_T[j][0];
    accum_i    = ACC_T[j][0];
    int_mode_i = INT_T[j][0];
    for (int t = 0; t < 4; t++) begin
      data_i[t*10 +: 10] = 10'(D_T[j][t]);
      coef_i[t*11 +: 11] = 11'(C_T[j][t]);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    oe_n_i = 1'b0;
    drive(0);
    repeat (3) @(negedge clk);
    check("R11 reset value", 32'(res_o), 32'h0);
    check("R10 drive flag", 32'(res_drv_o), 32'h1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: vector j captured at edge j, shown after edge j+2, sampled at negedge j+3
    for (int j = 0; j < NV + 3; j++) begin
      @(negedge clk);
      if (j >= 3) check({"R9/", tags[j-3]}, 32'(res_o), 32'(EXP_T[j-3]));
      if (j < NV) drive(j);
    end

    // R10: gating is immediate and leaves the register untouched
    oe_n_i = 1'b1;
    #1;
    check("R10 gated value", 32'(res_o), 32'h0);
    check("R10 drive flag low", 32'(res_drv_o), 32'h0);
    repeat (2) @(negedge clk);
    oe_n_i = 1'b0;
    #1;
    check("R10 value restored", 32'(res_o), 32'hE804);

    // R11: asynchronous clear mid-run
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1;
    check("R11 async clear", 32'(res_o), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 held through release", 32'(res_o), 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule